// File: doc/BRIEF.md
# DMA Transfer Configuration Checker

This block screens the setup of one DMA channel before a dual-address transfer is allowed to start. A request counts only when the software start bit or the external-request enable is set and a request strobe arrives. For each such request the block checks two things. Each address must be aligned to its own port size and use a legal size code. Neither link-channel number may name the channel itself. The block then gives a go or no-go decision one clock later.

A failed check sets a sticky configuration-error flag. If interrupts are enabled for the channel, it also fires a one-cycle interrupt pulse. A passing check fires a go pulse and publishes the byte count of each read/write transfer, which is the larger of the two port sizes. When the request came from the start bit, a pulse is also raised that clears that bit.

The surrounding channel logic uses the go pulse to launch bus accesses and the byte count to size them. Software clears the error flag with a dedicated clear strobe.

Top module: `dma_cfg_check`

## Requirements
- R1: A request is accepted when `req_i` is high together with `start_i` or `ext_en_i`, and `cfg_err_o` is low. The outcome (`go_o`, or error and interrupt) appears in the cycle after the request edge. With both `start_i` and `ext_en_i` low, `req_i` has no effect.
- R2: Size codes are 00 = 4 bytes, 01 = 1 byte, 10 = 2 bytes. An address is aligned when its low log2(bytes) bits are zero. An accepted request whose source or destination address is misaligned for its own size gives no `go_o` and sets `cfg_err_o`.
- R3: Size code 11 on either port is reserved. An accepted request that uses it gives no `go_o` and sets `cfg_err_o`.
- R4: An accepted request where `link1_ch_i` or `link2_ch_i` equals `cur_ch_i` gives no `go_o` and sets `cfg_err_o`.
- R5: On `go_o`, `xfer_bytes_o` shows the larger byte count of the two sizes (1, 2 or 4). It holds that value until the next `go_o`.
- R6: `irq_o` pulses for one cycle together with a newly set error, but only if `irq_en_i` was high at the request.
- R7: `start_clr_o` pulses together with `go_o` only when `start_i` was high at the request.
- R8: `cfg_err_o` stays set until `err_clr_i` is pulsed. While it is set, requests cause no `go_o`, no `irq_o`, no `start_clr_o` and no change to `xfer_bytes_o`.
- R9: `auto_align_i` does not relax any check. The outcome is identical with it high or low.
- R10: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_addr_i | input | ADDR_W | Source address |
| dst_addr_i | input | ADDR_W | Destination address |
| src_size_i | input | 2 | Source port size code |
| dst_size_i | input | 2 | Destination port size code |
| start_i | input | 1 | Software start bit |
| ext_en_i | input | 1 | External-request enable |
| req_i | input | 1 | Request strobe, internal or external |
| auto_align_i | input | 1 | Auto-align setting |
| irq_en_i | input | 1 | Interrupt enable for this channel |
| link1_ch_i | input | CH_W | First link channel number |
| link2_ch_i | input | CH_W | Second link channel number |
| cur_ch_i | input | CH_W | Index of this channel |
| err_clr_i | input | 1 | Clear strobe for the error flag |
| go_o | output | 1 | Transfer may start (pulse) |
| cfg_err_o | output | 1 | Sticky configuration error |
| irq_o | output | 1 | Error interrupt pulse |
| xfer_bytes_o | output | 3 | Bytes per read/write transfer |
| start_clr_o | output | 1 | Clear the start bit (pulse) |

## Verification
The hardest situation to reach from the ports is a request arriving while the sticky error is already set. Such a request must leave every output quiet, including the held byte count, and must not resurrect an interrupt. The stimulus provokes errors on purpose with misaligned addresses, reserved codes or self-links. It then fires further requests with valid settings and different sizes before clearing the flag, so that a leak shows as a go pulse or a changed byte count. Random runs also clear the flag only part of the time, so that requests land in both states.

// File: rtl/dma_cfg_pkg.sv
package dma_cfg_pkg;
  localparam int unsigned SIZE_W  = 2;
  localparam int unsigned BYTES_W = 3;
  localparam int unsigned NPORT   = 2;

  typedef enum logic [SIZE_W-1:0] {
    SZ_LONG = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } size_code_e;

  function automatic logic [BYTES_W-1:0] size_bytes(input logic [SIZE_W-1:0] code);
    case (code)
      SZ_LONG: size_bytes = 3'd4;
      SZ_BYTE: size_bytes = 3'd1;
      SZ_WORD: size_bytes = 3'd2;
      default: size_bytes = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/dma_addr_align.sv
module dma_addr_align
  import dma_cfg_pkg::*;
(
  input  logic [1:0]        addr_lo_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              ok_o
);
  always_comb begin
    case (size_i)
      SZ_BYTE: ok_o = 1'b1;
      SZ_WORD: ok_o = ~addr_lo_i[0];
      SZ_LONG: ok_o = (addr_lo_i == 2'b00);
      default: ok_o = 1'b0; // reserved code
    endcase
  end
endmodule

// File: rtl/dma_link_check.sv
module dma_link_check #(
  parameter int unsigned CH_W   = 2,
  parameter int unsigned NLINKS = 2
) (
  input  logic [NLINKS-1:0][CH_W-1:0] link_ch_i,
  input  logic [CH_W-1:0]             cur_ch_i,
  output logic                        self_ref_o
);
  logic [NLINKS-1:0] hit;
  for (genvar l = 0; l < NLINKS; l++) begin : g_link
    assign hit[l] = (link_ch_i[l] == cur_ch_i);
  end
  assign self_ref_o = |hit;
endmodule

// File: rtl/dma_size_max.sv
module dma_size_max
  import dma_cfg_pkg::*;
(
  input  logic [SIZE_W-1:0]  src_size_i,
  input  logic [SIZE_W-1:0]  dst_size_i,
  output logic [BYTES_W-1:0] bytes_o
);
  logic [BYTES_W-1:0] sb, db;
  assign sb = size_bytes(src_size_i);
  assign db = size_bytes(dst_size_i);
  assign bytes_o = (sb > db) ? sb : db;
endmodule

// File: rtl/dma_cfg_check.sv
module dma_cfg_check
  import dma_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CH_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  src_addr_i,
  input  logic [ADDR_W-1:0]  dst_addr_i,
  input  logic [SIZE_W-1:0]  src_size_i,
  input  logic [SIZE_W-1:0]  dst_size_i,
  input  logic               start_i,
  input  logic               ext_en_i,
  input  logic               req_i,
  input  logic               auto_align_i,
  input  logic               irq_en_i,
  input  logic [CH_W-1:0]    link1_ch_i,
  input  logic [CH_W-1:0]    link2_ch_i,
  input  logic [CH_W-1:0]    cur_ch_i,
  input  logic               err_clr_i,
  output logic               go_o,
  output logic               cfg_err_o,
  output logic               irq_o,
  output logic [BYTES_W-1:0] xfer_bytes_o,
  output logic               start_clr_o
);
  localparam int unsigned NLINKS = 2;

  logic [NPORT-1:0][1:0]        addr_lo;
  logic [NPORT-1:0][SIZE_W-1:0] port_size;
  logic [NPORT-1:0]             port_ok;
  logic [NLINKS-1:0][CH_W-1:0]  links;
  logic                         self_ref;
  logic [BYTES_W-1:0]           max_bytes;
  logic                         trig, accept, bad;
  logic                         unused_bits;

  assign addr_lo[0]   = src_addr_i[1:0];
  assign addr_lo[1]   = dst_addr_i[1:0];
  assign port_size[0] = src_size_i;
  assign port_size[1] = dst_size_i;
  assign links[0]     = link1_ch_i;
  assign links[1]     = link2_ch_i;

  // auto-align never bypasses checks; upper address bits do not affect alignment
  assign unused_bits = ^{src_addr_i[ADDR_W-1:2], dst_addr_i[ADDR_W-1:2], auto_align_i};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dma_addr_align u_align (
      .addr_lo_i (addr_lo[p]),
      .size_i    (port_size[p]),
      .ok_o      (port_ok[p])
    );
  end

  dma_link_check #(.CH_W(CH_W), .NLINKS(NLINKS)) u_link (
    .link_ch_i  (links),
    .cur_ch_i   (cur_ch_i),
    .self_ref_o (self_ref)
  );

  dma_size_max u_max (
    .src_size_i (src_size_i),
    .dst_size_i (dst_size_i),
    .bytes_o    (max_bytes)
  );

  assign trig   = req_i & (start_i | ext_en_i);
  assign accept = trig & ~cfg_err_o;
  assign bad    = ~(&port_ok) | self_ref;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_o         <= 1'b0;
      cfg_err_o    <= 1'b0;
      irq_o        <= 1'b0;
      start_clr_o  <= 1'b0;
      xfer_bytes_o <= '0;
    end else begin
      go_o        <= accept & ~bad;
      irq_o       <= accept & bad & irq_en_i;
      start_clr_o <= accept & ~bad & start_i;
      if (err_clr_i)         cfg_err_o <= 1'b0;
      else if (accept & bad) cfg_err_o <= 1'b1;
      if (accept & ~bad) xfer_bytes_o <= max_bytes;
    end
  end
endmodule

// File: rtl/dma_cfg_check_sva.sv
module dma_cfg_check_sva #(
  parameter int unsigned CH_W = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            ext_en_i,
  input logic            req_i,
  input logic            irq_en_i,
  input logic [CH_W-1:0] link1_ch_i,
  input logic [CH_W-1:0] link2_ch_i,
  input logic [CH_W-1:0] cur_ch_i,
  input logic            err_clr_i,
  input logic            go_o,
  input logic            cfg_err_o,
  input logic            irq_o,
  input logic [2:0]      xfer_bytes_o,
  input logic            start_clr_o
);
  a_r1_go_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> $past(req_i && (start_i || ext_en_i)));

  a_r4_no_go_on_self_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> $past(link1_ch_i != cur_ch_i && link2_ch_i != cur_ch_i));

  a_r5_bytes_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> (xfer_bytes_o == 3'd1 || xfer_bytes_o == 3'd2 || xfer_bytes_o == 3'd4));

  a_r6_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cfg_err_o && $past(irq_en_i) && !$past(cfg_err_o)));

  a_r7_start_clr_with_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_clr_o |-> (go_o && $past(start_i)));

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_err_o && !err_clr_i) |=> cfg_err_o);

  a_r8_quiet_when_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> (!go_o && $stable(xfer_bytes_o)));
endmodule

bind dma_cfg_check dma_cfg_check_sva #(.CH_W(CH_W)) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .ext_en_i     (ext_en_i),
  .req_i        (req_i),
  .irq_en_i     (irq_en_i),
  .link1_ch_i   (link1_ch_i),
  .link2_ch_i   (link2_ch_i),
  .cur_ch_i     (cur_ch_i),
  .err_clr_i    (err_clr_i),
  .go_o         (go_o),
  .cfg_err_o    (cfg_err_o),
  .irq_o        (irq_o),
  .xfer_bytes_o (xfer_bytes_o),
  .start_clr_o  (start_clr_o)
);

// File: tb/dma_cfg_check_test.sv
module dma_cfg_check_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int CH_W = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [ADDR_W-1:0] src_addr = '0, dst_addr = '0;
  logic [1:0] src_size = '0, dst_size = '0;
  logic start = 0, ext_en = 0, req = 0, aa = 0, irq_en = 0, err_clr = 0;
  logic [CH_W-1:0] l1 = 2'd1, l2 = 2'd2, cur = 2'd0;
  logic go, cfg_err, irq, start_clr;
  logic [2:0] xbytes;

  int errors = 0, checks = 0;
  logic exp_err = 0;
  logic [2:0] exp_bytes = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_cfg_check #(.ADDR_W(ADDR_W), .CH_W(CH_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .src_addr_i(src_addr), .dst_addr_i(dst_addr),
    .src_size_i(src_size), .dst_size_i(dst_size), .start_i(start), .ext_en_i(ext_en),
    .req_i(req), .auto_align_i(aa), .irq_en_i(irq_en), .link1_ch_i(l1),
    .link2_ch_i(l2), .cur_ch_i(cur), .err_clr_i(err_clr), .go_o(go),
    .cfg_err_o(cfg_err), .irq_o(irq), .xfer_bytes_o(xbytes), .start_clr_o(start_clr)
  );

  function automatic int nbytes(logic [1:0] c);
    case (c)
      2'b00: return 4;
      2'b01: return 1;
      2'b10: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic bit aligned(logic [ADDR_W-1:0] a, logic [1:0] c);
    int n = nbytes(c);
    if (n == 0) return 0;
    return (a % n) == 0;
  endfunction

  function automatic bit cfg_bad();
    return !aligned(src_addr, src_size) || !aligned(dst_addr, dst_size) ||
           l1 == cur || l2 == cur;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one request cycle at negedge, check outputs one clock later
  task automatic fire(string tag);
    bit acc, bad, trig;
    int e_go, e_irq, e_sclr;
    trig = req && (start || ext_en);
    acc = trig && !exp_err;
    bad = cfg_bad();
    e_go = acc && !bad;
    e_irq = acc && bad && irq_en;
    e_sclr = e_go && start;
    @(posedge clk);
    @(negedge clk);
    if (acc && bad) exp_err = 1;
    if (e_go) exp_bytes = 3'(nbytes(src_size) > nbytes(dst_size) ? nbytes(src_size) : nbytes(dst_size));
    check({tag, " go"}, go, e_go);
    check({tag, " err"}, cfg_err, exp_err);
    check({tag, " irq"}, irq, e_irq);
    check({tag, " start_clr"}, start_clr, e_sclr);
    check({tag, " bytes"}, xbytes, exp_bytes);
    req = 0;
  endtask

  task automatic clear_err();
    @(negedge clk);
    err_clr = 1;
    @(posedge clk);
    @(negedge clk);
    err_clr = 0;
    exp_err = 0;
    check("R8 clear", cfg_err, 0);
  endtask

  task automatic setup(logic [ADDR_W-1:0] sa, logic [ADDR_W-1:0] da, logic [1:0] ss, logic [1:0] ds,
                       logic s, logic e, logic [1:0] a1, logic [1:0] a2, logic [1:0] c);
    @(negedge clk);
    src_addr = sa; dst_addr = da; src_size = ss; dst_size = ds;
    start = s; ext_en = e; l1 = a1; l2 = a2; cur = c; req = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    #(CLK_PERIOD * 2 + 1);
    check("R10 go", go, 0);
    check("R10 err", cfg_err, 0);
    check("R10 irq", irq, 0);
    check("R10 start_clr", start_clr, 0);
    check("R10 bytes", xbytes, 0);
    @(negedge clk);
    rst_ni = 1;
    irq_en = 1;

    // R1: aligned long to byte, start bit
    setup(32'h100, 32'h203, 2'b00, 2'b01, 1, 0, 1, 2, 0); fire("R1 R5 R7 long/byte");
    // R7: external enable only, no start clear
    setup(32'h102, 32'h104, 2'b10, 2'b00, 0, 1, 2, 3, 1); fire("R7 ext only");
    // R1: no start, no ext -> ignored
    setup(32'h0, 32'h0, 2'b01, 2'b01, 0, 0, 1, 2, 0); fire("R1 untriggered");
    // R2: misaligned word source
    setup(32'h101, 32'h100, 2'b10, 2'b01, 1, 0, 1, 2, 0); fire("R2 src misaligned");
    // R8: valid request while error set is ignored
    setup(32'h0, 32'h0, 2'b01, 2'b10, 1, 1, 1, 2, 0); fire("R8 ignored");
    clear_err();
    // R2: misaligned long destination, irq disabled -> R6
    irq_en = 0;
    setup(32'h0, 32'h6, 2'b01, 2'b00, 1, 0, 1, 2, 0); fire("R2 R6 dst misaligned no irq");
    clear_err();
    irq_en = 1;
    // R3: reserved code
    setup(32'h0, 32'h0, 2'b11, 2'b01, 1, 0, 1, 2, 0); fire("R3 reserved");
    clear_err();
    // R4: self link on link2
    setup(32'h0, 32'h0, 2'b01, 2'b01, 1, 0, 1, 3, 3); fire("R4 self link2");
    clear_err();
    setup(32'h0, 32'h0, 2'b01, 2'b01, 1, 0, 2, 0, 2); fire("R4 self link1");
    clear_err();
    // R9: auto-align does not relax misalignment
    aa = 1;
    setup(32'h2, 32'h0, 2'b00, 2'b01, 1, 0, 1, 2, 0); fire("R9 aa misaligned");
    clear_err();
    setup(32'h8, 32'h4, 2'b00, 2'b10, 1, 0, 1, 2, 0); fire("R9 aa aligned");
    aa = 0;

    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      src_size = 2'($urandom_range(0, 15) == 0 ? 3 : $urandom_range(0, 2));
      dst_size = 2'($urandom_range(0, 15) == 0 ? 3 : $urandom_range(0, 2));
      src_addr = $urandom; dst_addr = $urandom;
      if ($urandom_range(0, 3) != 0) src_addr[1:0] = 2'b00;
      if ($urandom_range(0, 3) != 0) dst_addr[1:0] = 2'b00;
      cur = 2'($urandom); l1 = 2'($urandom); l2 = 2'($urandom);
      if ($urandom_range(0, 3) != 0) begin l1 = cur + 2'd1; l2 = cur + 2'd2; end
      start = 1'($urandom); ext_en = 1'($urandom);
      aa = 1'($urandom); irq_en = 1'($urandom);
      req = 1;
      fire("R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
      if (exp_err && $urandom_range(0, 2) == 0) clear_err();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule